// File: doc/BRIEF.md
# Floating-Point Round to Integral Value

This block takes one binary32 operand that has already been unpacked into a class code, a sign, a signed unbiased exponent and a normalized 24-bit significand (implicit bit in the top position), and returns the nearest integral value in the same unpacked form under one of six rounding modes. Before rounding, a signed power-of-two scale can be added to the exponent. The scale is first clamped to plus or minus 65536. The result carries an inexact flag and an invalid flag. Packing to 32 bits and conversion to an integer type are done elsewhere.

Operands enter through a valid/ready handshake, and the result leaves through one. A three-state controller sequences the work. In state IDLE the block is ready. The transition ACCEPT_SPECIAL takes a zero, infinity or NaN operand straight to DONE. The transition ACCEPT_NORMAL takes a finite nonzero operand to ROUND, where the scaled exponent selects the rounding position, and the transition ROUND_END then moves to DONE. DONE holds the result until the transition DRAIN, which is out_ready, returns the controller to IDLE. The scale is added while the operand is being accepted. The NaN handling also works on the live inputs at that point.

Top module: `rti_round_int`

## Requirements
- R1: in_ready is high only in IDLE. An operand is taken when in_valid and in_ready are both high. The result stays on the outputs, unchanged and with out_valid high, until out_ready is sampled high. No new operand is taken while a result is waiting.
- R2: Class codes are 0 zero, 1 normal, 2 infinity, 3 quiet NaN and 4 signaling NaN. out_valid rises one cycle after a non-normal operand is accepted, and two cycles after a normal operand is accepted.
- R3: For normal operands, in_scale (two's complement) is clamped to the range -65536..+65536 and added to the exponent before rounding. Zero, infinity and NaN operands ignore the scale.
- R4: A normal operand whose scaled exponent is negative gives either 1.0 (class 1, exponent 0, significand 0x800000) or zero (class 0, exponent 0, significand 0), with the input sign kept and inexact set. 1.0 is produced as follows: nearest-even when the exponent is -1 and any fraction bit below the implicit bit is set; ties-away when the exponent is -1; toward-zero never; toward +inf for positive values; toward -inf for negative values; round-to-odd always.
- R5: A normal operand whose scaled exponent is 23 or more is returned unchanged, with no flag set.
- R6: Mode codes are 0 nearest-even, 1 ties-away, 2 toward-zero, 3 toward +inf, 4 toward -inf and 5 round-to-odd. For scaled exponents 0..22, the integer lsb is significand bit 23-exponent. If the bits below the lsb are all zero, the value is unchanged and exact. Otherwise the value is rounded per the mode, the bits below the lsb are cleared, and inexact is set.
- R7: If rounding carries out of the significand, the result is significand 0x800000 with the exponent raised by one.
- R8: Mode codes 6 and 7 round toward zero.
- R9: A signaling NaN sets invalid and is returned as a quiet NaN (class 3) with fraction bit 22 set and all other bits kept. When in_dflt_nan is high it is instead replaced by the default NaN: class 3, sign 0, exponent 0, significand 0x400000.
- R10: A quiet NaN passes unchanged without flags, or becomes the default NaN when in_dflt_nan is high. Zero and infinity pass unchanged with no flags.
- R11: A normal result whose exponent is in 0..22 never has a set bit below its integer lsb, and it always has its top significand bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can take an operand |
| in_cls | input | 3 | Operand class code |
| in_sign | input | 1 | Operand sign |
| in_exp | input | EXP_W (20) | Signed unbiased exponent |
| in_sig | input | FRAC_W+1 (24) | Normalized significand or NaN payload |
| in_mode | input | 3 | Rounding mode code |
| in_scale | input | SCL_W (20) | Signed power-of-two scale |
| in_dflt_nan | input | 1 | Replace NaN results by the default NaN |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_cls | output | 3 | Result class code |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W (20) | Result exponent |
| out_sig | output | FRAC_W+1 (24) | Result significand |
| out_inexact | output | 1 | Value changed by rounding |
| out_invalid | output | 1 | Signaling NaN seen |

## Verification
The bench builds the block with its default parameters: FRAC_W=23 for binary32, EXP_W=20 and SCL_W=20. A 20-bit scale port can carry values such as +70000 and -100000, so the clamp is exercised on both sides. A 20-bit exponent holds the clamped sum, so a scaled exponent of 65536 can be checked as already integral. With FRAC_W=23 the rounding position covers the full range from bit 23 down to bit 1, which includes the half-unit tie at exponent 22 and the carry out of an all-ones significand.

// File: rtl/rti_pkg.sv
package rti_pkg;

    typedef enum logic [2:0] {
        CL_ZERO = 3'd0,
        CL_NORM = 3'd1,
        CL_INF  = 3'd2,
        CL_QNAN = 3'd3,
        CL_SNAN = 3'd4
    } fcls_e;

    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_NEAR_AWAY = 3'd1,
        RM_ZERO      = 3'd2,
        RM_UP        = 3'd3,
        RM_DOWN      = 3'd4,
        RM_ODD       = 3'd5
    } rmode_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ROUND = 2'd1,
        S_DONE  = 2'd2
    } rti_state_e;

endpackage

// File: rtl/rti_scale.sv
module rti_scale #(
    parameter int EXP_W     = 20,
    parameter int SCL_W     = 20,
    parameter int SCALE_LIM = 65536
) (
    input  logic signed [EXP_W-1:0] exp_i,
    input  logic signed [SCL_W-1:0] scale_i,
    output logic signed [EXP_W-1:0] exp_o
);
    localparam int CW = ((SCL_W > EXP_W) ? SCL_W : EXP_W) + 2;
    localparam logic signed [CW-1:0] LIM_P = CW'(SCALE_LIM);
    localparam logic signed [CW-1:0] LIM_N = -LIM_P;

    logic signed [CW-1:0] scl_x;
    logic signed [CW-1:0] exp_x;
    logic signed [CW-1:0] scl_c;
    logic signed [CW-1:0] sum;

    always_comb begin
        scl_x = {{(CW-SCL_W){scale_i[SCL_W-1]}}, scale_i};
        exp_x = {{(CW-EXP_W){exp_i[EXP_W-1]}}, exp_i};
        if (scl_x > LIM_P) begin
            scl_c = LIM_P;
        end else if (scl_x < LIM_N) begin
            scl_c = LIM_N;
        end else begin
            scl_c = scl_x;
        end
        sum   = exp_x + scl_c;
        exp_o = sum[EXP_W-1:0];
    end
endmodule

// File: rtl/rti_nan.sv
module rti_nan
    import rti_pkg::*;
#(
    parameter int FRAC_W = 23,
    parameter int EXP_W  = 20
) (
    input  logic [2:0]        cls_i,
    input  logic              sign_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W:0]   sig_i,
    input  logic              dflt_i,
    output fcls_e             cls_o,
    output logic              sign_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [FRAC_W:0]   sig_o,
    output logic              invalid_o
);
    localparam int QBIT = FRAC_W - 1;
    localparam logic [FRAC_W:0] DFLT_SIG = (FRAC_W+1)'(1) << QBIT;

    logic is_nan;
    logic is_snan;

    always_comb begin
        is_snan   = (cls_i == CL_SNAN);
        is_nan    = is_snan || (cls_i == CL_QNAN);
        cls_o     = fcls_e'(cls_i);
        sign_o    = sign_i;
        exp_o     = exp_i;
        sig_o     = sig_i;
        invalid_o = is_snan;
        if (is_nan) begin
            cls_o = CL_QNAN;
            if (dflt_i) begin
                sign_o = 1'b0;
                exp_o  = '0;
                sig_o  = DFLT_SIG;
            end else begin
                sig_o[QBIT] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rti_frac.sv
module rti_frac
    import rti_pkg::*;
#(
    parameter int FRAC_W = 23,
    parameter int EXP_W  = 20
) (
    input  logic                    sign_i,
    input  logic signed [EXP_W-1:0] exp_i,
    input  logic [FRAC_W:0]         sig_i,
    input  logic [2:0]              mode_i,
    output fcls_e                   cls_o,
    output logic signed [EXP_W-1:0] exp_o,
    output logic [FRAC_W:0]         sig_o,
    output logic                    inexact_o
);
    localparam int SW = FRAC_W + 1;
    localparam logic signed [EXP_W-1:0] EXP_FW  = EXP_W'(FRAC_W);
    localparam logic signed [EXP_W-1:0] EXP_ONE = EXP_W'(1);
    localparam logic [SW-1:0] ONE_SIG = SW'(1) << FRAC_W;

    logic          below, whole, neg_one, rest_nz, one;
    logic [EXP_W-1:0] pos;
    logic [SW-1:0] lsb_m, rnd_m, half_m, even_m, inc;
    logic [SW:0]   sum, clr;
    rmode_e        md;

    always_comb begin
        below   = (exp_i < 0);
        whole   = (exp_i >= EXP_FW);
        neg_one = (exp_i == -EXP_ONE);
        rest_nz = |sig_i[FRAC_W-1:0];
        pos     = EXP_FW - exp_i;
        lsb_m   = (below || whole) ? '0 : (SW'(1) << pos);
        rnd_m   = lsb_m - SW'(1);
        half_m  = lsb_m >> 1;
        even_m  = rnd_m | lsb_m;
        md      = (mode_i > 3'd5) ? RM_ZERO : rmode_e'(mode_i);

        case (md)
            RM_NEAR_EVEN: begin
                inc = ((sig_i & even_m) != half_m) ? half_m : '0;
                one = neg_one && rest_nz;
            end
            RM_NEAR_AWAY: begin
                inc = half_m;
                one = neg_one;
            end
            RM_UP: begin
                inc = sign_i ? '0 : rnd_m;
                one = !sign_i;
            end
            RM_DOWN: begin
                inc = sign_i ? rnd_m : '0;
                one = sign_i;
            end
            RM_ODD: begin
                inc = ((sig_i & lsb_m) != '0) ? '0 : rnd_m;
                one = 1'b1;
            end
            default: begin
                inc = '0;
                one = 1'b0;
            end
        endcase

        sum = {1'b0, sig_i} + {1'b0, inc};
        clr = sum & ~{1'b0, rnd_m};

        cls_o     = CL_NORM;
        exp_o     = exp_i;
        sig_o     = sig_i;
        inexact_o = 1'b0;
        if (below) begin
            inexact_o = 1'b1;
            exp_o     = '0;
            sig_o     = one ? ONE_SIG : '0;
            cls_o     = one ? CL_NORM : CL_ZERO;
        end else if (!whole && ((sig_i & rnd_m) != '0)) begin
            inexact_o = 1'b1;
            if (clr[SW]) begin
                sig_o = clr[SW:1];
                exp_o = exp_i + EXP_ONE;
            end else begin
                sig_o = clr[SW-1:0];
            end
        end
    end
endmodule

// File: rtl/rti_round_int.sv
module rti_round_int
    import rti_pkg::*;
#(
    parameter int FRAC_W    = 23,
    parameter int EXP_W     = 20,
    parameter int SCL_W     = 20,
    parameter int SCALE_LIM = 65536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_cls,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [FRAC_W:0]   in_sig,
    input  logic [2:0]        in_mode,
    input  logic [SCL_W-1:0]  in_scale,
    input  logic              in_dflt_nan,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [2:0]        out_cls,
    output logic              out_sign,
    output logic [EXP_W-1:0]  out_exp,
    output logic [FRAC_W:0]   out_sig,
    output logic              out_inexact,
    output logic              out_invalid
);
    rti_state_e state, state_nx;

    logic                    take;
    logic                    take_norm;
    logic signed [EXP_W-1:0] exp_scaled;
    logic                    h_sign;
    logic signed [EXP_W-1:0] h_exp;
    logic [FRAC_W:0]         h_sig;
    logic [2:0]              h_mode;

    fcls_e                   sp_cls;
    logic                    sp_sign;
    logic [EXP_W-1:0]        sp_exp;
    logic [FRAC_W:0]         sp_sig;
    logic                    sp_inv;

    fcls_e                   rd_cls;
    logic signed [EXP_W-1:0] rd_exp;
    logic [FRAC_W:0]         rd_sig;
    logic                    rd_inx;

    rti_scale #(.EXP_W(EXP_W), .SCL_W(SCL_W), .SCALE_LIM(SCALE_LIM)) u_scale (
        .exp_i   ($signed(in_exp)),
        .scale_i ($signed(in_scale)),
        .exp_o   (exp_scaled)
    );

    rti_nan #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_nan (
        .cls_i     (in_cls),
        .sign_i    (in_sign),
        .exp_i     (in_exp),
        .sig_i     (in_sig),
        .dflt_i    (in_dflt_nan),
        .cls_o     (sp_cls),
        .sign_o    (sp_sign),
        .exp_o     (sp_exp),
        .sig_o     (sp_sig),
        .invalid_o (sp_inv)
    );

    rti_frac #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_frac (
        .sign_i    (h_sign),
        .exp_i     (h_exp),
        .sig_i     (h_sig),
        .mode_i    (h_mode),
        .cls_o     (rd_cls),
        .exp_o     (rd_exp),
        .sig_o     (rd_sig),
        .inexact_o (rd_inx)
    );

    assign in_ready  = (state == S_IDLE);
    assign out_valid = (state == S_DONE);
    assign take      = in_valid && in_ready;
    assign take_norm = take && (in_cls == CL_NORM);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (take) state_nx = take_norm ? S_ROUND : S_DONE;
            S_ROUND: state_nx = S_DONE;
            S_DONE:  if (out_ready) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_sign      <= 1'b0;
            h_exp       <= '0;
            h_sig       <= '0;
            h_mode      <= '0;
            out_cls     <= CL_ZERO;
            out_sign    <= 1'b0;
            out_exp     <= '0;
            out_sig     <= '0;
            out_inexact <= 1'b0;
            out_invalid <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (take_norm) begin
                        h_sign <= in_sign;
                        h_exp  <= exp_scaled;
                        h_sig  <= in_sig;
                        h_mode <= in_mode;
                    end else if (take) begin
                        out_cls     <= sp_cls;
                        out_sign    <= sp_sign;
                        out_exp     <= sp_exp;
                        out_sig     <= sp_sig;
                        out_inexact <= 1'b0;
                        out_invalid <= sp_inv;
                    end
                end
                S_ROUND: begin
                    out_cls     <= rd_cls;
                    out_sign    <= h_sign;
                    out_exp     <= rd_exp;
                    out_sig     <= rd_sig;
                    out_inexact <= rd_inx;
                    out_invalid <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    p_busy_no_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_hold_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sig) && $stable(out_exp)
                                       && $stable(out_cls) && $stable(out_sign)));

    p_special_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_cls != CL_NORM) |=> out_valid);

    p_normal_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_norm |=> !out_valid ##1 out_valid);

    p_invalid_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (out_cls == CL_QNAN && out_sig[FRAC_W-1] && !out_inexact));

    p_integral_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cls == CL_NORM && $signed(out_exp) >= 0 && $signed(out_exp) < FRAC_W)
        |-> (out_sig[FRAC_W] && ((out_sig >> (FRAC_W - out_exp)) << (FRAC_W - out_exp)) == out_sig));

endmodule

// File: tb/sim_rti_round_int.sv
module sim_rti_round_int;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 37;

    typedef struct packed {
        logic [2:0]  cls;
        logic        sgn;
        logic [19:0] ex;
        logic [23:0] sg;
        logic [2:0]  md;
        logic [19:0] sc;
        logic        dn;
        logic [2:0]  ecls;
        logic        esgn;
        logic [19:0] eex;
        logic [23:0] esg;
        logic        einx;
        logic        einv;
    } vec_t;

    localparam vec_t VT [NV] = '{
        '{3'd1,1'b0,20'h00001,24'hA00000,3'd0,20'h0,1'b0, 3'd1,1'b0,20'h00001,24'h800000,1'b1,1'b0}, // R6 2.5 ne -> 2
        '{3'd1,1'b0,20'h00001,24'hA00000,3'd1,20'h0,1'b0, 3'd1,1'b0,20'h00001,24'hC00000,1'b1,1'b0}, // R6 2.5 away -> 3
        '{3'd1,1'b0,20'h00001,24'hE00000,3'd0,20'h0,1'b0, 3'd1,1'b0,20'h00002,24'h800000,1'b1,1'b0}, // R7 3.5 ne -> 4
        '{3'd1,1'b0,20'h00001,24'hA00000,3'd2,20'h0,1'b0, 3'd1,1'b0,20'h00001,24'h800000,1'b1,1'b0}, // R6 tz
        '{3'd1,1'b0,20'h00001,24'hA00000,3'd3,20'h0,1'b0, 3'd1,1'b0,20'h00001,24'hC00000,1'b1,1'b0}, // R6 up +
        '{3'd1,1'b1,20'h00001,24'hA00000,3'd3,20'h0,1'b0, 3'd1,1'b1,20'h00001,24'h800000,1'b1,1'b0}, // R6 up -
        '{3'd1,1'b1,20'h00001,24'hA00000,3'd4,20'h0,1'b0, 3'd1,1'b1,20'h00001,24'hC00000,1'b1,1'b0}, // R6 down -
        '{3'd1,1'b0,20'h00001,24'hA00000,3'd5,20'h0,1'b0, 3'd1,1'b0,20'h00001,24'hC00000,1'b1,1'b0}, // R6 odd 2.5
        '{3'd1,1'b0,20'h00001,24'hE00000,3'd5,20'h0,1'b0, 3'd1,1'b0,20'h00001,24'hC00000,1'b1,1'b0}, // R6 odd 3.5
        '{3'd1,1'b0,20'h00001,24'hC00000,3'd0,20'h0,1'b0, 3'd1,1'b0,20'h00001,24'hC00000,1'b0,1'b0}, // R6 exact
        '{3'd1,1'b0,20'h00016,24'h800001,3'd0,20'h0,1'b0, 3'd1,1'b0,20'h00016,24'h800000,1'b1,1'b0}, // R6 tie at bit 1
        '{3'd1,1'b0,20'h00002,24'hFFFFFF,3'd3,20'h0,1'b0, 3'd1,1'b0,20'h00003,24'h800000,1'b1,1'b0}, // R7 carry
        '{3'd1,1'b0,20'hFFFFF,24'hC00000,3'd0,20'h0,1'b0, 3'd1,1'b0,20'h00000,24'h800000,1'b1,1'b0}, // R4 0.75 ne
        '{3'd1,1'b0,20'hFFFFF,24'h800000,3'd0,20'h0,1'b0, 3'd0,1'b0,20'h00000,24'h000000,1'b1,1'b0}, // R4 0.5 ne
        '{3'd1,1'b0,20'hFFFFF,24'h800000,3'd1,20'h0,1'b0, 3'd1,1'b0,20'h00000,24'h800000,1'b1,1'b0}, // R4 0.5 away
        '{3'd1,1'b0,20'hFFFFE,24'h800000,3'd1,20'h0,1'b0, 3'd0,1'b0,20'h00000,24'h000000,1'b1,1'b0}, // R4 0.25 away
        '{3'd1,1'b0,20'hFFFFE,24'h800000,3'd3,20'h0,1'b0, 3'd1,1'b0,20'h00000,24'h800000,1'b1,1'b0}, // R4 up +
        '{3'd1,1'b1,20'hFFFFE,24'h800000,3'd3,20'h0,1'b0, 3'd0,1'b1,20'h00000,24'h000000,1'b1,1'b0}, // R4 up -
        '{3'd1,1'b1,20'hFFFFE,24'h800000,3'd4,20'h0,1'b0, 3'd1,1'b1,20'h00000,24'h800000,1'b1,1'b0}, // R4 down -
        '{3'd1,1'b0,20'hFFFFE,24'h800000,3'd5,20'h0,1'b0, 3'd1,1'b0,20'h00000,24'h800000,1'b1,1'b0}, // R4 odd
        '{3'd1,1'b0,20'hFFFFF,24'hC00000,3'd2,20'h0,1'b0, 3'd0,1'b0,20'h00000,24'h000000,1'b1,1'b0}, // R4 tz
        '{3'd1,1'b0,20'h00017,24'h800001,3'd0,20'h0,1'b0, 3'd1,1'b0,20'h00017,24'h800001,1'b0,1'b0}, // R5 exp 23
        '{3'd1,1'b0,20'h0001E,24'hFFFFFF,3'd3,20'h0,1'b0, 3'd1,1'b0,20'h0001E,24'hFFFFFF,1'b0,1'b0}, // R5 exp 30
        '{3'd1,1'b0,20'h00000,24'hC00000,3'd0,20'h00001,1'b0, 3'd1,1'b0,20'h00001,24'hC00000,1'b0,1'b0}, // R3 +1
        '{3'd1,1'b0,20'h00000,24'hC00000,3'd0,20'hFFFFF,1'b0, 3'd1,1'b0,20'h00000,24'h800000,1'b1,1'b0}, // R3 -1
        '{3'd1,1'b0,20'h00000,24'hC00000,3'd0,20'h186A0,1'b0, 3'd1,1'b0,20'h10000,24'hC00000,1'b0,1'b0}, // R3 clamp hi
        '{3'd1,1'b0,20'h00000,24'hC00000,3'd0,20'h11170,1'b0, 3'd1,1'b0,20'h10000,24'hC00000,1'b0,1'b0}, // R3 clamp 70000
        '{3'd1,1'b0,20'h00000,24'hC00000,3'd3,20'hE7960,1'b0, 3'd1,1'b0,20'h00000,24'h800000,1'b1,1'b0}, // R3 clamp lo
        '{3'd1,1'b0,20'h00001,24'hA00000,3'd7,20'h0,1'b0, 3'd1,1'b0,20'h00001,24'h800000,1'b1,1'b0}, // R8 mode 7
        '{3'd1,1'b1,20'h00001,24'hA00000,3'd6,20'h0,1'b0, 3'd1,1'b1,20'h00001,24'h800000,1'b1,1'b0}, // R8 mode 6
        '{3'd0,1'b1,20'h00000,24'h000000,3'd3,20'h00005,1'b0, 3'd0,1'b1,20'h00000,24'h000000,1'b0,1'b0}, // R10 zero
        '{3'd2,1'b0,20'h00080,24'h000000,3'd0,20'h00005,1'b0, 3'd2,1'b0,20'h00080,24'h000000,1'b0,1'b0}, // R10 inf
        '{3'd3,1'b1,20'h00080,24'h400123,3'd0,20'h0,1'b0, 3'd3,1'b1,20'h00080,24'h400123,1'b0,1'b0}, // R10 qnan
        '{3'd4,1'b0,20'h00080,24'h000123,3'd0,20'h0,1'b0, 3'd3,1'b0,20'h00080,24'h400123,1'b0,1'b1}, // R9 quiet
        '{3'd4,1'b1,20'h00080,24'h000123,3'd0,20'h0,1'b1, 3'd3,1'b0,20'h00000,24'h400000,1'b0,1'b1}, // R9 default
        '{3'd3,1'b1,20'h00080,24'h400123,3'd0,20'h0,1'b1, 3'd3,1'b0,20'h00000,24'h400000,1'b0,1'b0}, // R10 default
        '{3'd1,1'b1,20'h00001,24'hE00000,3'd0,20'h0,1'b1, 3'd1,1'b1,20'h00002,24'h800000,1'b1,1'b0}  // R11 R7 neg carry
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_cls = '0;
    logic        in_sign = 1'b0;
    logic [19:0] in_exp = '0;
    logic [23:0] in_sig = '0;
    logic [2:0]  in_mode = '0;
    logic [19:0] in_scale = '0;
    logic        in_dflt_nan = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [2:0]  out_cls;
    logic        out_sign;
    logic [19:0] out_exp;
    logic [23:0] out_sig;
    logic        out_inexact;
    logic        out_invalid;

    int errs = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rti_round_int u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig),
        .in_mode(in_mode), .in_scale(in_scale), .in_dflt_nan(in_dflt_nan),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_cls(out_cls), .out_sign(out_sign), .out_exp(out_exp), .out_sig(out_sig),
        .out_inexact(out_inexact), .out_invalid(out_invalid)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [51:0] outs();
        return {out_cls, out_sign, out_exp, out_sig, out_inexact, out_invalid};
    endfunction

    task automatic load(input vec_t v);
        in_cls = v.cls; in_sign = v.sgn; in_exp = v.ex; in_sig = v.sg;
        in_mode = v.md; in_scale = v.sc; in_dflt_nan = v.dn;
    endtask

    task automatic issue(input vec_t v, output int lat);
        @(negedge clk);
        load(v);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 50) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic drain();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errs++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int lat;
        logic [51:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset", {in_ready, out_valid}, 2'b10);

        for (int i = 0; i < NV; i++) begin
            vec_t v = VT[i];
            logic [51:0] expv = {v.ecls, v.esgn, v.eex, v.esg, v.einx, v.einv};
            int elat = (v.cls == 3'd1) ? 2 : 1;
            issue(v, lat);
            // R2 latency
            check(lat == elat, $sformatf("R2 latency vec %0d", i), lat, elat);
            // R3..R11 per the table comments
            check(outs() == expv, $sformatf("R3-class result vec %0d", i), outs(), expv);
            drain();
        end

        // R1 back-pressure: result held, new operand ignored
        issue(VT[0], lat);
        held = outs();
        @(negedge clk);
        load(VT[1]);
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check(in_ready == 1'b0 && out_valid == 1'b1, "R1 busy", {in_ready, out_valid}, 2'b01);
        check(outs() == held, "R1 hold", outs(), held);
        in_valid = 1'b0;
        drain();
        check(out_valid == 1'b0 && in_ready == 1'b1, "R1 drained", {in_ready, out_valid}, 2'b10);

        // R10 scale ignored by infinity with a large scale
        issue('{3'd2,1'b1,20'h00080,24'h0,3'd0,20'h186A0,1'b0, 3'd2,1'b1,20'h00080,24'h0,1'b0,1'b0}, lat);
        check(out_exp == 20'h00080 && out_cls == 3'd2, "R10 inf scale", {out_cls, out_exp}, {3'd2, 20'h00080});
        drain();

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule